// File: doc/BRIEF.md
# Staged Per-Core Watchdog Timer

This block holds one watchdog per processor core. Each watchdog counts down from a programmed length. If software does not service it in time, the watchdog steps through three stages. The first time the count runs out, it raises an interrupt. The second time, it raises a non-maskable interrupt. The third time, it asks for a soft reset of the whole chip. Every stage lasts one full period, and all periods are the same length.

The count is a wide decrementer. A 16-bit length value is loaded into its upper bits, and its low bits are loaded with all ones. A free-running prescaler lets the decrementer move one step every 2^PRE_W clocks. With the defaults (8 low bits, 8 prescaler bits) one period can last up to 2^32 clocks.

Software sets the length and an escalation mode through a write port that selects one core. A per-core poke strobe restarts the period and returns that core to its first stage. A read port shows the stage, mode and length of the selected core. The parameter NUM_CORES sets how many identical watchdogs are built.

Top module: `wdt_cluster`

## Requirements
- R1: After reset every core is in stage 0 with mode 0 and length 0. Its interrupt, NMI and soft-reset outputs are low, and its readback is all zeros.
- R2: A reload sets the decrementer to {length, 2^LOW_W-1 ones} and clears the prescaler. The period therefore ends exactly (length+1)*2^(LOW_W+PRE_W) clocks after the reload edge, and the count then reloads by itself for the next period.
- R3: When a period ends in stage 0, the core moves to stage 1. Its interrupt output rises and stays high until a poke or a configuration write clears it.
- R4: When a period ends in stage 1 and the mode is 2 or 3, the core moves to stage 2. Its NMI output rises and stays high until cleared.
- R5: When a period ends in stage 2 and the mode is 3, the core moves to stage 3 and drives its soft-reset request high for exactly one clock. The core then stays in stage 3 with the interrupt and NMI held and no further pulse.
- R6: In mode 1 the core stops at stage 1, and in mode 2 it stops at stage 2. In both modes the counter keeps running, but no soft-reset request is ever made.
- R7: Mode 0 disables the core. It never leaves stage 0 and its outputs stay low, whatever length is programmed.
- R8: A poke reloads the counter and returns the core to stage 0. If a poke comes in the same clock as a period end, the poke wins.
- R9: A configuration write to a core stores the new length and mode, reloads the counter and returns the core to stage 0.
- R10: The readback for the selected core is {length, mode[1:0], stage[1:0]}, with stage in bits 1:0 and mode in bits 3:2. Bit 1 is set exactly when the core has reached the NMI stage or beyond.
- R11: Cores are independent. A write or poke addressed to one core leaves the stage and outputs of every other core unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_core | input | CORE_W | Core selected by the write |
| cfg_len | input | LEN_W | Period length written |
| cfg_mode | input | 2 | Escalation mode written (0 off, 1 interrupt, 2 up to NMI, 3 up to reset) |
| poke | input | NUM_CORES | Per-core service strobe |
| rd_core | input | CORE_W | Core whose status is read |
| rd_data | output | LEN_W+4 | Status of the read core: {length, mode, stage} |
| irq | output | NUM_CORES | Per-core interrupt level |
| nmi | output | NUM_CORES | Per-core non-maskable interrupt level |
| srst_req | output | NUM_CORES | Per-core one-clock soft-reset request |

## Verification
The bench measures the stage on the clock edge just before each period boundary and on the boundary itself. An off-by-one in the prescaler or in the low-bit reload would move an escalation by one tick, and those samples would catch it. It drives a poke into the very cycle a period ends. A design that let the expiry win would be left in the interrupt stage. It counts soft-reset pulses in modes 1, 2 and 3, and keeps counting after stage 3. This catches a request that was made too early, one that repeated or was held high, and one made in a mode that should stop short. It also shows whether escalation stopped at the right stage in the limited modes and whether a disabled core stayed quiet.

// File: rtl/wdt_pkg.sv
// Package of shared types for the staged watchdog.
// Assumes the 2-bit mode and 2-bit stage encodings listed in the brief.
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_IRQ   = 2'd1,
        ST_NMI   = 2'd2,
        ST_RESET = 2'd3
    } wdt_stage_e;

    localparam logic [1:0] MODE_OFF  = 2'd0;
    localparam logic [1:0] MODE_IRQ  = 2'd1;
    localparam logic [1:0] MODE_NMI  = 2'd2;
    localparam logic [1:0] MODE_FULL = 2'd3;

endpackage

// File: rtl/wdt_prescaler.sv
// Prescaler: divides the clock by 2^PRE_W and gives one tick per wrap.
// Assumes clear has priority over run. While run is low, the count holds.
module wdt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);

    logic [PRE_W-1:0] pre_q;

    // purpose: a tick marks the last clock of each prescaler wrap
    always_comb tick = run && !clear && (&pre_q);

    // purpose: advance the prescaler while the core is enabled
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0));                              // R2

endmodule

// File: rtl/wdt_decrementer.sv
// Period decrementer: holds {length, ones} and counts down once per tick.
// When a tick arrives at zero it flags expire and reloads itself.
// Assumes reload has priority over tick.
module wdt_decrementer #(
    parameter int LEN_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len,
    input  logic             reload,
    input  logic             tick,
    output logic             expire
);

    localparam int CNT_W = LEN_W + LOW_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] start_val;

    // purpose: form the start value of each period
    always_comb start_val = {len, {LOW_W{1'b1}}};

    // purpose: a period ends on a tick that finds the count at zero
    always_comb expire = tick && !reload && (cnt_q == '0);

    // purpose: load on reload or at the end of a period, count down on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload || expire) begin
            cnt_q <= start_val;
        end else if (tick) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !tick) |=> $stable(cnt_q));               // R2
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2

endmodule

// File: rtl/wdt_escalator.sv
// Stage machine: moves up one stage at each period end, as far as the mode allows.
// At the step into the reset stage it gives a one-clock soft-reset request.
// Assumes expire only comes while the core is enabled, and clear wins over expire.
module wdt_escalator
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       expire,
    input  logic [1:0] mode,
    output wdt_stage_e stage,
    output logic       irq,
    output logic       nmi,
    output logic       srst
);

    wdt_stage_e stage_q;
    logic       srst_q;

    // purpose: step the stage at each period end, limited by the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= ST_ARMED;
            srst_q  <= 1'b0;
        end else begin
            srst_q <= 1'b0;
            if (clear) begin
                stage_q <= ST_ARMED;
            end else if (expire) begin
                unique case (stage_q)
                    ST_ARMED: if (mode != MODE_OFF)  stage_q <= ST_IRQ;
                    ST_IRQ:   if (mode == MODE_NMI || mode == MODE_FULL) stage_q <= ST_NMI;
                    ST_NMI:   if (mode == MODE_FULL) begin
                                  stage_q <= ST_RESET;
                                  srst_q  <= 1'b1;
                              end
                    ST_RESET: stage_q <= ST_RESET;
                    default:  stage_q <= ST_ARMED;
                endcase
            end
        end
    end

    // purpose: turn the held stage into level outputs
    always_comb begin
        stage = stage_q;
        irq   = (stage_q != ST_ARMED);
        nmi   = (stage_q == ST_NMI) || (stage_q == ST_RESET);
        srst  = srst_q;
    end

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear) |=> irq);                             // R3
    AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi && !clear) |=> nmi);                             // R4
    AST_SRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !srst);                                      // R5
    AST_SRST_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        srst |-> (mode == MODE_FULL));                        // R6
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> (stage_q == ST_ARMED));        // R7
    AST_CLEAR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (stage_q == ST_ARMED && !srst_q));          // R8
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && stage_q != ST_RESET) |=>
            (stage_q == $past(stage_q) || stage_q == wdt_stage_e'($past(stage_q) + 2'd1))); // R3

endmodule

// File: rtl/wdt_core.sv
// One watchdog core: configuration registers, prescaler, decrementer and stage machine.
// A write to this core or a poke reloads the period and clears the stage.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int LOW_W = 8,
    parameter int PRE_W = 8,
    localparam int RD_W = LEN_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_hit,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             poke,
    output logic [RD_W-1:0]  status,
    output logic             irq,
    output logic             nmi,
    output logic             srst
);

    logic [LEN_W-1:0] len_q;
    logic [1:0]       mode_q;
    logic [LEN_W-1:0] len_next;
    logic             clear;
    logic             run;
    logic             tick;
    logic             expire;
    wdt_stage_e       stage;

    // purpose: latch length and mode on a write addressed to this core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            mode_q <= MODE_OFF;
        end else if (cfg_hit) begin
            len_q  <= cfg_len;
            mode_q <= cfg_mode;
        end
    end

    // purpose: derive the shared restart, the enable and the length to load
    always_comb begin
        clear    = poke || cfg_hit;
        run      = (mode_q != MODE_OFF);
        len_next = cfg_hit ? cfg_len : len_q;
        status   = {len_q, mode_q, stage};
    end

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (clear),
        .tick  (tick)
    );

    wdt_decrementer #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .len    (len_next),
        .reload (clear),
        .tick   (tick),
        .expire (expire)
    );

    wdt_escalator u_esc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .expire (expire),
        .mode   (mode_q),
        .stage  (stage),
        .irq    (irq),
        .nmi    (nmi),
        .srst   (srst)
    );

    AST_CFG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> (len_q == $past(cfg_len) && mode_q == $past(cfg_mode))); // R9

endmodule

// File: rtl/wdt_cluster.sv
// Top level: NUM_CORES watchdog cores sharing one write port and one read port.
// Assumes cfg_core and rd_core address an existing core. A read of any other value returns zero.
module wdt_cluster #(
    parameter int NUM_CORES = 4,
    parameter int LEN_W     = 16,
    parameter int LOW_W     = 8,
    parameter int PRE_W     = 8,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CORE_W-1:0]    cfg_core,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [1:0]           cfg_mode,
    input  logic [NUM_CORES-1:0] poke,
    input  logic [CORE_W-1:0]    rd_core,
    output logic [LEN_W+3:0]     rd_data,
    output logic [NUM_CORES-1:0] irq,
    output logic [NUM_CORES-1:0] nmi,
    output logic [NUM_CORES-1:0] srst_req
);

    localparam int RD_W = LEN_W + 4;

    logic [RD_W-1:0] status [NUM_CORES];

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        logic hit;

        // purpose: decode the write strobe for this core
        always_comb hit = cfg_we && (cfg_core == CORE_W'(g));

        wdt_core #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_hit  (hit),
            .cfg_len  (cfg_len),
            .cfg_mode (cfg_mode),
            .poke     (poke[g]),
            .status   (status[g]),
            .irq      (irq[g]),
            .nmi      (nmi[g]),
            .srst     (srst_req[g])
        );

        AST_OTHER_CORE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit && !poke[g] && irq[g]) |=> irq[g]);         // R11
    end

    // purpose: select the status word of the read core
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (rd_core == CORE_W'(i)) rd_data = status[i];
        end
    end

endmodule

// File: tb/wdt_cluster_test.sv
// Bench for wdt_cluster with a short period (LOW_W=2, PRE_W=2): period = 16*(len+1) clocks.
module wdt_cluster_test;

    localparam int NC    = 2;
    localparam int LEN_W = 16;
    localparam int CW    = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CW-1:0]     cfg_core = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [1:0]        cfg_mode = '0;
    logic [NC-1:0]     poke = '0;
    logic [CW-1:0]     rd_core = '0;
    logic [LEN_W+3:0]  rd_data;
    logic [NC-1:0]     irq;
    logic [NC-1:0]     nmi;
    logic [NC-1:0]     srst_req;

    int total = 0;
    int bad = 0;
    int pulses0 = 0;
    int pulses1 = 0;

    always #10 clk = ~clk;

    wdt_cluster #(.NUM_CORES(NC), .LEN_W(LEN_W), .LOW_W(2), .PRE_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_core(cfg_core),
        .cfg_len(cfg_len), .cfg_mode(cfg_mode), .poke(poke), .rd_core(rd_core),
        .rd_data(rd_data), .irq(irq), .nmi(nmi), .srst_req(srst_req)
    );

    always @(negedge clk) begin
        if (srst_req[0]) pulses0++;
        if (srst_req[1]) pulses1++;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input int core, input int mode, input int len);
        cfg_core = CW'(core);
        cfg_mode = 2'(mode);
        cfg_len  = LEN_W'(len);
        cfg_we   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic do_poke(input int core);
        poke[core] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        poke = '0;
    endtask

    task automatic chk_core0(input string req, input int stg);
        rd_core = '0;
        #1;
        chk(req, int'(rd_data[1:0]), stg);
        chk(req, int'(irq[0]), (stg >= 1) ? 1 : 0);
        chk(req, int'(nmi[0]), (stg >= 2) ? 1 : 0);
    endtask

    // vector table: mode, len, cycles after the write, expected stage
    localparam int NV = 11;
    localparam int V_MODE [NV] = '{3, 3, 3, 3, 3, 1, 2, 3, 3, 0, 3};
    localparam int V_LEN  [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 5, 2};
    localparam int V_WAIT [NV] = '{15, 16, 31, 32, 48, 40, 60, 31, 32, 100, 95};
    localparam int V_STG  [NV] = '{0, 1, 1, 2, 3, 1, 2, 0, 1, 0, 1};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int p;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during and after reset
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 nmi", int'(nmi), 0);
        rst_n = 1'b1;
        wait_cyc(40);
        chk("R1 srst", int'(srst_req), 0);
        chk("R1 idle stage", int'(rd_data), 0);

        // R2 R3 R4 R5 R6 R7 R9 table walk: each row begins with a write that reloads
        for (int v = 0; v < NV; v++) begin
            write_cfg(0, V_MODE[v], V_LEN[v]);
            wait_cyc(V_WAIT[v]);
            chk_core0($sformatf("R2 R3 R4 row %0d", v), V_STG[v]);
            chk("R10 mode field", int'(rd_data[3:2]), V_MODE[v]);
            chk("R10 len field", int'(rd_data[LEN_W+3:4]), V_LEN[v]);
        end

        // R5: single pulse on the third expiry, then held
        p = pulses0;
        write_cfg(0, 3, 0);
        wait_cyc(47);
        chk("R5 no pulse before third expiry", int'(srst_req[0]), 0);
        wait_cyc(1);
        chk("R5 pulse at third expiry", int'(srst_req[0]), 1);
        wait_cyc(1);
        chk("R5 pulse lasts one clock", int'(srst_req[0]), 0);
        wait_cyc(60);
        chk_core0("R5 stage 3 held", 3);
        chk("R5 pulse count", pulses0 - p, 1);
        chk("R10 bit1 at nmi or beyond", int'(rd_data[1]), 1);

        // R6: limited modes never request reset
        p = pulses0;
        write_cfg(0, 2, 0);
        wait_cyc(120);
        chk_core0("R6 mode 2 stops at nmi", 2);
        write_cfg(0, 1, 0);
        wait_cyc(120);
        chk_core0("R6 mode 1 stops at irq", 1);
        chk("R10 bit1 clear in irq stage", int'(rd_data[1]), 0);
        chk("R6 no pulse in modes 1 and 2", pulses0 - p, 0);

        // R8: poke clears the stage and restarts a full period
        write_cfg(0, 3, 0);
        wait_cyc(36);
        chk_core0("R8 before poke", 2);
        do_poke(0);
        chk_core0("R8 poke clears", 0);
        wait_cyc(15);
        chk_core0("R8 full period after poke", 0);
        wait_cyc(1);
        chk_core0("R8 expiry after poke", 1);

        // R8: poke in the same cycle as the period end wins
        write_cfg(0, 3, 0);
        wait_cyc(15);
        do_poke(0);
        chk_core0("R8 poke beats expiry", 0);
        wait_cyc(15);
        chk_core0("R8 restarted period", 0);
        wait_cyc(1);
        chk_core0("R8 restarted expiry", 1);

        // R9: a write during stage 2 clears it
        write_cfg(0, 3, 0);
        wait_cyc(40);
        write_cfg(0, 3, 1);
        chk_core0("R9 write clears stage", 0);
        wait_cyc(32);
        chk_core0("R9 new length used", 1);

        // R7: poke while disabled changes nothing
        write_cfg(0, 0, 0);
        do_poke(0);
        wait_cyc(50);
        chk_core0("R7 disabled core quiet", 0);

        // R11: cores are independent
        write_cfg(1, 3, 0);
        wait_cyc(20);
        chk("R11 core1 irq", int'(irq[1]), 1);
        chk("R11 core0 untouched", int'(irq[0]), 0);
        do_poke(0);
        write_cfg(0, 1, 3);
        rd_core = 1'b1;
        #1;
        chk("R11 core1 stage kept", int'(rd_data[1:0]), 1);
        chk("R11 core1 mode read", int'(rd_data[3:2]), 3);
        rd_core = 1'b0;
        #1;
        chk("R11 core0 fresh stage", int'(rd_data[1:0]), 0);
        chk("R11 core0 no pulse", int'(srst_req[0]), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule